// File: doc/BRIEF.md
# AHB to APB Bus Bridge

This block is a slave on an AHB-Lite style system bus. Each selected read or write it accepts becomes one access on a peripheral bus of the APB kind. The peripheral bus is not pipelined, so the bridge holds HREADY low until the peripheral access has finished. Only then does it accept the next transfer.

The bridge registers the address and the write flag in the AHB address phase. It registers the write data in the following cycle. All peripheral-side outputs come from those registers. A write uses three data-phase cycles: data capture, APB setup, and APB access, with HREADY high in the access cycle. A read also uses three: APB setup, APB access (where the read word is registered), and a return cycle that presents the word with HREADY high.

Accesses are always one full word. Transfer size and the byte-lane address bits are ignored. A simple decode of an address field picks one of several peripheral selects. The enable strobe is high for exactly one cycle per access and is the only timing reference the peripherals get.

Top module: `ahb_apb_bridge`

## Requirements
- R1: After a synchronous active-low reset, every select and the enable output are low, HREADY is high and HRESP is 0.
- R2: A transfer is accepted when HSEL is 1, HTRANS is NONSEQ (2'b10) or SEQ (2'b11), and HREADY is high at a rising edge. Each accepted transfer produces exactly one cycle with enable high.
- R3: IDLE (2'b00) or BUSY (2'b01) transfers, or any transfer with HSEL low, start no APB access. HREADY stays high and peripheral contents are unchanged.
- R4: Each APB access is one setup cycle (select high, enable low) followed by one access cycle (select and enable high). Address, write data, write flag and select are identical in both cycles. The enable strobe never lasts longer than one cycle.
- R5: A write holds HREADY low in its first two data-phase cycles and raises it in the third, which is the access cycle. The written word is the HWDATA value present in the first data-phase cycle, even if HWDATA changes afterwards.
- R6: A read holds HREADY low in its two APB cycles. In the third cycle HREADY is high and HRDATA equals the peripheral data sampled in the access cycle.
- R7: Accesses are always full 32-bit words. HSIZE has no effect, PADDR bits [1:0] are always 0, and all 32 write-data bits are driven.
- R8: Exactly one select bit is driven during an access: bit i, where i is address bits [13:12] (for 4 peripherals).
- R9: HRESP is always 0 (OKAY).
- R10: A transfer presented in the cycle where HREADY returns high is accepted at that edge. Its APB setup cycle follows immediately, with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| hclk | input | 1 | Clock shared by both bus sides |
| hresetn | input | 1 | Synchronous reset, active low |
| hsel | input | 1 | Bridge selected by the system decoder |
| haddr | input | 32 | Transfer address |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | 1 for write, 0 for read |
| hsize | input | 3 | Transfer size, ignored (word only) |
| hwdata | input | 32 | Write data, valid in the data phase |
| hready | output | 1 | Transfer done / bridge ready |
| hresp | output | 1 | Response, always OKAY |
| hrdata | output | 32 | Read data returned to the master |
| paddr | output | 32 | Peripheral address, word aligned |
| psel | output | 4 | One-hot peripheral select |
| penable | output | 1 | Access strobe, one cycle per access |
| pwrite | output | 1 | Peripheral write flag |
| pwdata | output | 32 | Peripheral write data |
| prdata | input | 32 | Read data from the selected peripheral |

## Verification
The hardest case to reach is the chained handover. A new address phase lands in the same cycle that an earlier access finishes. It is hard because the bridge accepts it only while HREADY is high, and HREADY rises for a single cycle. The stimulus waits for that cycle, presents a read of the word just written, and then chains a second read from the return cycle. This shows both that the write has landed and that no idle gap appears. A second hard case is the write data arriving a cycle after its address. The bench replaces HWDATA with junk right after the capture cycle, so a bridge that samples late puts the wrong word on the peripheral bus.

// File: rtl/bridge_pkg.sv
// Package: bridge_pkg
// Shared state encoding and transfer-type codes for the bus bridge.
// Assumes a single clock domain and AHB-Lite transfer-type encoding.
package bridge_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_WLAT   = 3'd1,
        ST_SETUP  = 3'd2,
        ST_ACCESS = 3'd3,
        ST_RDONE  = 3'd4
    } brg_state_e;

    localparam logic [1:0] TR_IDLE   = 2'b00;
    localparam logic [1:0] TR_BUSY   = 2'b01;
    localparam logic [1:0] TR_NONSEQ = 2'b10;
    localparam logic [1:0] TR_SEQ    = 2'b11;

endpackage

// File: rtl/bridge_ctrl.sv
// Module: bridge_ctrl
// Sequencer for the bridge. It decides when a system-bus transfer is taken,
// steps through capture, setup, access and read-return, and drives the
// ready flag and the load strobes for the capture registers.
// Assumes the master holds its address phase while ready is low.
module bridge_ctrl
    import bridge_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel,
    input  logic [1:0] trans,
    input  logic       write_in,
    input  logic       wr_q,
    output logic       take,
    output logic       ready,
    output logic       load_wdata,
    output logic       load_rdata,
    output logic       apb_on,
    output logic       apb_en
);

    brg_state_e state_q;
    brg_state_e state_d;
    brg_state_e start_st;

    // ready is high when idle, in read return, and in the write access cycle
    always_comb begin
        ready = (state_q == ST_IDLE) || (state_q == ST_RDONE) ||
                ((state_q == ST_ACCESS) && wr_q);
    end

    // a transfer is taken only when selected, active and ready
    always_comb begin
        take = ready && sel && ((trans == TR_NONSEQ) || (trans == TR_SEQ));
        start_st = write_in ? ST_WLAT : ST_SETUP;
    end

    // next-state selection
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:   state_d = take ? start_st : ST_IDLE;
            ST_WLAT:   state_d = ST_SETUP;
            ST_SETUP:  state_d = ST_ACCESS;
            ST_ACCESS: state_d = wr_q ? (take ? start_st : ST_IDLE) : ST_RDONE;
            ST_RDONE:  state_d = take ? start_st : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // decoded controls for the capture registers and the peripheral side
    always_comb begin
        load_wdata = (state_q == ST_WLAT);
        load_rdata = (state_q == ST_ACCESS) && !wr_q;
        apb_on     = (state_q == ST_SETUP) || (state_q == ST_ACCESS);
        apb_en     = (state_q == ST_ACCESS);
    end

    // R5/R6: the setup cycle of an access never completes the system-bus transfer
    assert_setup_waits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETUP) |-> !ready);

    // R6: a read access cycle always leads to a return cycle with ready high
    assert_read_returns_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (apb_en && !wr_q) |=> ready);

endmodule

// File: rtl/bridge_regs.sv
// Module: bridge_regs
// Capture registers: address and write flag from the address phase,
// write data from the data phase, read data from the access cycle.
// Assumes load strobes are one-cycle pulses from the sequencer.
module bridge_regs #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_addr,
    input  logic              load_wdata,
    input  logic              load_rdata,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              write_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic [DATA_W-1:0] rdata_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic              wr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);

    // address and direction captured in the address phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            wr_q   <= 1'b0;
        end else if (load_addr) begin
            addr_q <= addr_in;
            wr_q   <= write_in;
        end
    end

    // write data captured one cycle after the address
    always_ff @(posedge clk) begin
        if (!rst_n)          wdata_q <= '0;
        else if (load_wdata) wdata_q <= wdata_in;
    end

    // read data captured at the end of the access cycle
    always_ff @(posedge clk) begin
        if (!rst_n)          rdata_q <= '0;
        else if (load_rdata) rdata_q <= rdata_in;
    end

endmodule

// File: rtl/bridge_decode.sv
// Module: bridge_decode
// Turns an address field into a one-hot peripheral select, gated by the
// sequencer's access-active flag.
// Assumes NUM_SLV is a power of two so every field value maps to a select.
module bridge_decode #(
    parameter int ADDR_W  = 32,
    parameter int NUM_SLV = 4,
    parameter int SEL_LSB = 12
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               active,
    output logic [NUM_SLV-1:0] sel
);

    localparam int IDX_W = (NUM_SLV > 1) ? $clog2(NUM_SLV) : 1;

    logic [IDX_W-1:0] idx;

    // pick the select field out of the registered address
    always_comb idx = addr[SEL_LSB +: IDX_W];

    // one comparator per peripheral select
    for (genvar gi = 0; gi < NUM_SLV; gi++) begin : g_sel
        always_comb sel[gi] = active && (idx == IDX_W'(gi));
    end

endmodule

// File: rtl/ahb_apb_bridge.sv
// Module: ahb_apb_bridge
// System-bus slave that converts each accepted transfer into a single
// full-word peripheral access and stalls the master until it is done.
// Assumes one clock for both sides, AHB-Lite masters, fixed-length
// peripheral accesses (no peripheral wait states) and word-only data.
module ahb_apb_bridge #(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int NUM_SLV = 4,
    parameter int SEL_LSB = 12
) (
    input  logic               hclk,
    input  logic               hresetn,
    input  logic               hsel,
    input  logic [ADDR_W-1:0]  haddr,
    input  logic [1:0]         htrans,
    input  logic               hwrite,
    input  logic [2:0]         hsize,
    input  logic [DATA_W-1:0]  hwdata,
    output logic               hready,
    output logic               hresp,
    output logic [DATA_W-1:0]  hrdata,
    output logic [ADDR_W-1:0]  paddr,
    output logic [NUM_SLV-1:0] psel,
    output logic               penable,
    output logic               pwrite,
    output logic [DATA_W-1:0]  pwdata,
    input  logic [DATA_W-1:0]  prdata
);

    localparam int LANE_W = $clog2(DATA_W / 8);
    localparam logic [ADDR_W-1:0] LANE_MASK = ADDR_W'((1 << LANE_W) - 1);
    localparam logic [2:0] MAX_SIZE = 3'(LANE_W);

    logic              take;
    logic              load_wdata;
    logic              load_rdata;
    logic              apb_on;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;

    bridge_ctrl u_ctrl (
        .clk        (hclk),
        .rst_n      (hresetn),
        .sel        (hsel),
        .trans      (htrans),
        .write_in   (hwrite),
        .wr_q       (wr_q),
        .take       (take),
        .ready      (hready),
        .load_wdata (load_wdata),
        .load_rdata (load_rdata),
        .apb_on     (apb_on),
        .apb_en     (penable)
    );

    bridge_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk        (hclk),
        .rst_n      (hresetn),
        .load_addr  (take),
        .load_wdata (load_wdata),
        .load_rdata (load_rdata),
        .addr_in    (haddr),
        .write_in   (hwrite),
        .wdata_in   (hwdata),
        .rdata_in   (prdata),
        .addr_q     (addr_q),
        .wr_q       (wr_q),
        .wdata_q    (pwdata),
        .rdata_q    (hrdata)
    );

    bridge_decode #(.ADDR_W(ADDR_W), .NUM_SLV(NUM_SLV), .SEL_LSB(SEL_LSB)) u_dec (
        .addr   (addr_q),
        .active (apb_on),
        .sel    (psel)
    );

    // word-aligned peripheral address, write flag and fixed OKAY response
    always_comb begin
        paddr  = addr_q & ~LANE_MASK;
        pwrite = wr_q;
        hresp  = 1'b0;
    end

    // R7: only sizes up to one word may be issued to this slave
    assert_size_in_word_R7: assert property (@(posedge hclk) disable iff (!hresetn)
        take |-> (hsize <= MAX_SIZE));

    // R8: at most one peripheral selected at a time
    assert_sel_onehot_R8: assert property (@(posedge hclk) disable iff (!hresetn)
        $onehot0(psel));

    // R4: the enable strobe follows a setup cycle and is itself selected
    assert_enable_after_setup_R4: assert property (@(posedge hclk) disable iff (!hresetn)
        penable |-> ((|psel) && $past((|psel) && !penable)));

    // R4: the enable strobe lasts one cycle only
    assert_enable_single_R4: assert property (@(posedge hclk) disable iff (!hresetn)
        penable |=> !penable);

    // R4: peripheral address, data, direction and select hold from setup to access
    assert_apb_stable_R4: assert property (@(posedge hclk) disable iff (!hresetn)
        penable |-> ($stable(paddr) && $stable(pwdata) && $stable(psel) && $stable(pwrite)));

    // R5: the master is stalled during every setup cycle
    assert_wait_in_setup_R5: assert property (@(posedge hclk) disable iff (!hresetn)
        ((|psel) && !penable) |-> !hready);

endmodule

// File: tb/ahb_apb_bridge_bench.sv
// Directed bench for ahb_apb_bridge with a small peripheral memory model.
module ahb_apb_bridge_bench;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int NS = 4;

    logic          hclk = 1'b0;
    logic          hresetn = 1'b0;
    logic          hsel = 1'b0;
    logic [AW-1:0] haddr = '0;
    logic [1:0]    htrans = 2'b00;
    logic          hwrite = 1'b0;
    logic [2:0]    hsize = 3'd2;
    logic [DW-1:0] hwdata = '0;
    logic          hready;
    logic          hresp;
    logic [DW-1:0] hrdata;
    logic [AW-1:0] paddr;
    logic [NS-1:0] psel;
    logic          penable;
    logic          pwrite;
    logic [DW-1:0] pwdata;
    logic [DW-1:0] prdata;

    int total = 0;
    int bad = 0;
    int strobes = 0;
    int cycles = 0;

    logic [DW-1:0] mem [NS*16];
    logic [1:0]    sidx;

    ahb_apb_bridge #(.ADDR_W(AW), .DATA_W(DW), .NUM_SLV(NS), .SEL_LSB(12)) u_ahb_apb_bridge (
        .hclk(hclk), .hresetn(hresetn), .hsel(hsel), .haddr(haddr), .htrans(htrans),
        .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata), .hready(hready), .hresp(hresp),
        .hrdata(hrdata), .paddr(paddr), .psel(psel), .penable(penable), .pwrite(pwrite),
        .pwdata(pwdata), .prdata(prdata)
    );

    always #2 hclk = ~hclk;

    // peripheral model: index from select, word from paddr[5:2]
    always_comb begin
        sidx = 2'd0;
        for (int i = 0; i < NS; i++) if (psel[i]) sidx = 2'(i);
        prdata = (|psel) ? mem[{sidx, paddr[5:2]}] : 32'h0;
    end

    always @(posedge hclk) begin
        if (hresetn && penable) strobes <= strobes + 1;
        if (hresetn && (|psel) && penable && pwrite) mem[{sidx, paddr[5:2]}] <= pwdata;
    end

    // watchdog
    always @(posedge hclk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog act=%0d exp=<20000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge hclk);
        @(negedge hclk);
    endtask

    task automatic addr_ph(input logic [31:0] a, input logic wr, input logic [1:0] tr,
                           input logic [2:0] sz);
        hsel = 1'b1; haddr = a; hwrite = wr; htrans = tr; hsize = sz;
    endtask

    task automatic go_idle();
        htrans = 2'b00; hsel = 1'b0;
    endtask

    function automatic logic [3:0] exp_sel(input logic [31:0] a);
        return 4'(1 << a[13:12]);
    endfunction

    // R1: reset state
    task automatic t_reset();
        hresetn = 1'b0;
        step(); step();
        chk("R1 psel", 32'(psel), 32'h0);
        chk("R1 penable", 32'(penable), 32'h0);
        chk("R1 hready", 32'(hready), 32'h1);
        chk("R1 hresp", 32'(hresp), 32'h0);
        hresetn = 1'b1;
        step();
        chk("R1 hready after release", 32'(hready), 32'h1);
    endtask

    // R2 R4 R5 R7 R8: single write, checked cycle by cycle
    task automatic t_write(input logic [31:0] a, input logic [31:0] d,
                           input logic [1:0] tr, input logic [2:0] sz);
        int s0 = strobes;
        addr_ph(a, 1'b1, tr, sz);
        step();                      // capture cycle
        hwdata = d;
        go_idle();
        chk("R5 ready low capture", 32'(hready), 32'h0);
        chk("R4 no sel in capture", 32'(psel), 32'h0);
        step();                      // setup
        hwdata = ~d;                 // junk: must not be used
        chk("R5 ready low setup", 32'(hready), 32'h0);
        chk("R8 sel setup", 32'(psel), 32'(exp_sel(a)));
        chk("R4 enable low setup", 32'(penable), 32'h0);
        chk("R7 paddr aligned", paddr, {a[31:2], 2'b00});
        chk("R4 pwrite setup", 32'(pwrite), 32'h1);
        step();                      // access
        chk("R5 ready high access", 32'(hready), 32'h1);
        chk("R4 enable access", 32'(penable), 32'h1);
        chk("R4 sel access", 32'(psel), 32'(exp_sel(a)));
        chk("R5 R7 pwdata", pwdata, d);
        chk("R9 hresp", 32'(hresp), 32'h0);
        step();
        chk("R2 one strobe", 32'(strobes - s0), 32'h1);
        chk("R4 enable dropped", 32'(penable), 32'h0);
    endtask

    // R2 R6 R8: single read
    task automatic t_read(input logic [31:0] a, input logic [31:0] exp);
        int s0 = strobes;
        addr_ph(a, 1'b0, 2'b10, 3'd2);
        step();                      // setup
        go_idle();
        chk("R6 ready low setup", 32'(hready), 32'h0);
        chk("R8 sel read", 32'(psel), 32'(exp_sel(a)));
        chk("R4 pwrite read", 32'(pwrite), 32'h0);
        step();                      // access
        chk("R6 ready low access", 32'(hready), 32'h0);
        chk("R4 enable read", 32'(penable), 32'h1);
        step();                      // return
        chk("R6 ready return", 32'(hready), 32'h1);
        chk("R6 hrdata", hrdata, exp);
        chk("R9 hresp read", 32'(hresp), 32'h0);
        step();
        chk("R2 one read strobe", 32'(strobes - s0), 32'h1);
    endtask

    // R3: idle, busy and unselected transfers do nothing
    task automatic t_ignored();
        int s0 = strobes;
        addr_ph(32'h0000_1004, 1'b1, 2'b01, 3'd2);   // BUSY
        hwdata = 32'hDEAD_0001;
        step();
        chk("R3 busy no sel", 32'(psel), 32'h0);
        chk("R3 busy ready", 32'(hready), 32'h1);
        addr_ph(32'h0000_1004, 1'b1, 2'b00, 3'd2);   // IDLE
        step();
        chk("R3 idle no sel", 32'(psel), 32'h0);
        chk("R3 idle ready", 32'(hready), 32'h1);
        addr_ph(32'h0000_1004, 1'b1, 2'b10, 3'd2);
        hsel = 1'b0;                                 // unselected NONSEQ
        step();
        chk("R3 unsel no sel", 32'(psel), 32'h0);
        chk("R3 unsel ready", 32'(hready), 32'h1);
        chk("R3 unsel hresp", 32'(hresp), 32'h0);
        go_idle();
        step(); step();
        chk("R3 no strobes", 32'(strobes - s0), 32'h0);
    endtask

    // R10: chained write -> read -> read with no idle gap
    task automatic t_chain(input logic [31:0] old1004);
        addr_ph(32'h0000_2010, 1'b1, 2'b10, 3'd2);
        step();                      // capture
        hwdata = 32'hC0DE_2010;
        go_idle();
        step();                      // setup
        hwdata = 32'h0;
        step();                      // access, ready high
        chk("R10 write ready", 32'(hready), 32'h1);
        addr_ph(32'h0000_2010, 1'b0, 2'b10, 3'd2);
        step();                      // read setup immediately
        chk("R10 read setup sel", 32'(psel), 32'h4);
        chk("R10 read setup enable", 32'(penable), 32'h0);
        chk("R10 read setup dir", 32'(pwrite), 32'h0);
        go_idle();
        step();                      // access
        step();                      // return
        chk("R6 R10 read back", hrdata, 32'hC0DE_2010);
        chk("R10 return ready", 32'(hready), 32'h1);
        addr_ph(32'h0000_1004, 1'b0, 2'b11, 3'd2);
        step();                      // second read setup
        chk("R10 second setup sel", 32'(psel), 32'h2);
        go_idle();
        step(); step();
        chk("R10 second data", hrdata, old1004);
        step();
    endtask

    initial begin
        for (int i = 0; i < NS*16; i++) mem[i] = 32'h0;
        t_reset();
        t_write(32'h0000_1004, 32'hA5A5_1234, 2'b10, 3'd2);
        t_read(32'h0000_1004, 32'hA5A5_1234);
        t_write(32'h0000_300B, 32'h8765_4321, 2'b11, 3'd0);   // byte size, odd address
        t_read(32'h0000_300A, 32'h8765_4321);
        t_write(32'h0000_0000, 32'h0F0F_F0F0, 2'b10, 3'd1);
        t_read(32'h0000_0000, 32'h0F0F_F0F0);
        t_ignored();
        t_read(32'h0000_1004, 32'hA5A5_1234);                 // R3: value untouched
        t_chain(32'hA5A5_1234);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule